// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block computes and holds the processor status word that follows byte-wide or word-wide add and subtract operations. Each cycle the datapath presents both operands, the result its adder produced, whether the operation was a subtraction, and whether it was a byte or a word operation. When the update enable is high, the unit registers six arithmetic flags:

- carry or borrow
- parity
- auxiliary (nibble) carry
- zero
- sign
- signed overflow

Three control flags sit alongside the arithmetic flags: single-step trap, interrupt enable and string direction. Each control flag has its own set and clear inputs. All nine flags are packed into one 16-bit word. That word is always visible at the output and can be overwritten in one cycle, for example when a saved status word is restored.

Top module: `status_flag_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the flag word reads 16'h0002.
- R2: The word layout is: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt bit 9, direction bit 10, overflow bit 11. Bit 1 always reads 1, and bits 3, 5 and 15:12 always read 0, even after a load.
- R3: Carry is set on an add when there is a carry out of the most significant bit of the selected size. On a subtract (op_sub=1) it is set on a borrow, meaning the unsigned first operand is less than the second.
- R4: The auxiliary flag is set on a carry out of bit 3 into bit 4 for an add, or on a borrow from bit 4 into bit 3 for a subtract.
- R5: The zero flag is 1 when the result, within the selected size, is all zero; otherwise it is 0.
- R6: The sign flag equals the most significant bit of the result in the selected size (bit 7 for bytes, bit 15 for words).
- R7: The overflow flag is set when the two's-complement add or subtract leaves the signed range of the selected size.
- R8: The parity flag is 1 when bits 7:0 of the result hold an even number of ones.
- R9: When size_word is 0, only bits 7:0 of the operands and the result affect the flags; the upper bits are ignored.
- R10: When neither upd_en nor load_en is high, the six arithmetic flags keep their values.
- R11: A set input makes its control flag 1 on the next edge, and a clear input makes it 0; when both are high, clear wins. An arithmetic update leaves the control flags unchanged.
- R12: When load_en is high, the next edge writes load_word into the flag word, with the fixed bits of R2 forced. A load takes priority over upd_en and over every set and clear input.
- R13: Flags update one clock edge after their inputs are sampled; the output is the registered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Register the arithmetic flags for this operation |
| op_sub | input | 1 | 1: subtract (first minus second), 0: add |
| size_word | input | 1 | 1: word operation, 0: byte operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| alu_res | input | 16 | Result produced by the adder |
| set_trap | input | 1 | Set single-step trap flag |
| clr_trap | input | 1 | Clear single-step trap flag |
| set_int | input | 1 | Set interrupt-enable flag |
| clr_int | input | 1 | Clear interrupt-enable flag |
| set_dir | input | 1 | Set direction flag (descending) |
| clr_dir | input | 1 | Clear direction flag (ascending) |
| load_en | input | 1 | Overwrite the whole flag word |
| load_word | input | 16 | Word to load |
| flag_word | output | 16 | Packed status word |

## Verification
The bench builds the unit with its default DATA_W of 16, which gives a byte half of 8 bits and a parity width of 8. At that size, every pair of byte operands can be applied for both add and subtract within the run. This covers every nibble carry, every signed wrap and every parity pattern of the byte path exhaustively. The upper operand and result bytes carry unrelated values throughout the sweep, which tests that they are ignored. The word path is covered by named corner pairs around 16'h7FFF, 16'h8000 and 16'hFFFF, followed by a few thousand pseudo-random pairs.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int FLAG_W  = 16;
    localparam int POS_CF  = 0;
    localparam int POS_ONE = 1;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_TF  = 8;
    localparam int POS_IF  = 9;
    localparam int POS_DF  = 10;
    localparam int POS_OF  = 11;

    typedef struct packed {
        logic carry;
        logic parity;
        logic aux;
        logic zero;
        logic sign;
        logic ovf;
    } arith_flags_t;

    // order trap, intr, dir from MSB to LSB
    typedef struct packed {
        logic trap;
        logic intr;
        logic dir;
    } ctrl_flags_t;

    localparam int CTRL_N = $bits(ctrl_flags_t);

    typedef struct packed {
        arith_flags_t arith;
        ctrl_flags_t  ctrl;
    } flag_state_t;

    function automatic logic [FLAG_W-1:0] pack_word(flag_state_t s);
        logic [FLAG_W-1:0] w;
        w          = '0;
        w[POS_ONE] = 1'b1;
        w[POS_CF]  = s.arith.carry;
        w[POS_PF]  = s.arith.parity;
        w[POS_AF]  = s.arith.aux;
        w[POS_ZF]  = s.arith.zero;
        w[POS_SF]  = s.arith.sign;
        w[POS_OF]  = s.arith.ovf;
        w[POS_TF]  = s.ctrl.trap;
        w[POS_IF]  = s.ctrl.intr;
        w[POS_DF]  = s.ctrl.dir;
        return w;
    endfunction

    function automatic flag_state_t unpack_word(logic [FLAG_W-1:0] w);
        flag_state_t s;
        s.arith.carry  = w[POS_CF];
        s.arith.parity = w[POS_PF];
        s.arith.aux    = w[POS_AF];
        s.arith.zero   = w[POS_ZF];
        s.arith.sign   = w[POS_SF];
        s.arith.ovf    = w[POS_OF];
        s.ctrl.trap    = w[POS_TF];
        s.ctrl.intr    = w[POS_IF];
        s.ctrl.dir     = w[POS_DF];
        return s;
    endfunction

endpackage

// File: rtl/sfu_parity.sv
module sfu_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    output logic         even
);
    logic [W:0] acc;
    assign acc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign acc[i+1] = acc[i] ^ bits[i];
    end

    assign even = ~acc[W];
endmodule

// File: rtl/sfu_arith_flags.sv
module sfu_arith_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              sub,
    input  logic              word,
    output logic              carry,
    output logic              aux,
    output logic              zero,
    output logic              sign,
    output logic              ovf
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int NIB    = 4;

    logic [DATA_W:0] wide_ext;
    logic [BYTE_W:0] byte_ext;
    logic            a_m, b_m, r_m;

    always_comb begin
        if (sub) begin
            wide_ext = {1'b0, a} - {1'b0, b};
            byte_ext = {1'b0, a[BYTE_W-1:0]} - {1'b0, b[BYTE_W-1:0]};
        end else begin
            wide_ext = {1'b0, a} + {1'b0, b};
            byte_ext = {1'b0, a[BYTE_W-1:0]} + {1'b0, b[BYTE_W-1:0]};
        end

        a_m = word ? a[DATA_W-1]   : a[BYTE_W-1];
        b_m = word ? b[DATA_W-1]   : b[BYTE_W-1];
        r_m = word ? res[DATA_W-1] : res[BYTE_W-1];

        carry = word ? wide_ext[DATA_W] : byte_ext[BYTE_W];
        aux   = a[NIB] ^ b[NIB] ^ res[NIB];
        zero  = word ? ~|res : ~|res[BYTE_W-1:0];
        sign  = r_m;
        if (sub)
            ovf = (a_m != b_m) && (r_m != a_m);
        else
            ovf = (a_m == b_m) && (r_m != a_m);
    end
endmodule

// File: rtl/sfu_ctrl_next.sv
module sfu_ctrl_next #(
    parameter int N = 3
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign nxt[i] = clr_v[i] ? 1'b0 : (set_v[i] ? 1'b1 : cur[i]);
    end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              op_sub,
    input  logic              size_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              set_trap,
    input  logic              clr_trap,
    input  logic              set_int,
    input  logic              clr_int,
    input  logic              set_dir,
    input  logic              clr_dir,
    input  logic              load_en,
    input  logic [FLAG_W-1:0] load_word,
    output logic [FLAG_W-1:0] flag_word
);
    flag_state_t       state_d, state_q;
    arith_flags_t      arith_new;
    logic              par_even;
    logic [CTRL_N-1:0] ctrl_nxt;

    sfu_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (alu_res),
        .sub   (op_sub),
        .word  (size_word),
        .carry (arith_new.carry),
        .aux   (arith_new.aux),
        .zero  (arith_new.zero),
        .sign  (arith_new.sign),
        .ovf   (arith_new.ovf)
    );

    sfu_parity #(.W(PAR_W)) u_par (
        .bits (alu_res[PAR_W-1:0]),
        .even (par_even)
    );
    assign arith_new.parity = par_even;

    sfu_ctrl_next #(.N(CTRL_N)) u_ctrl (
        .cur   (state_q.ctrl),
        .set_v ({set_trap, set_int, set_dir}),
        .clr_v ({clr_trap, clr_int, clr_dir}),
        .nxt   (ctrl_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ctrl = ctrl_nxt;
        if (upd_en)
            state_d.arith = arith_new;
        if (load_en)
            state_d = unpack_word(load_word);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign flag_word = pack_word(state_q);
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_en,
    input logic              size_word,
    input logic [DATA_W-1:0] alu_res,
    input logic              set_trap,
    input logic              clr_trap,
    input logic              set_int,
    input logic              clr_int,
    input logic              set_dir,
    input logic              clr_dir,
    input logic              load_en,
    input logic [15:0]       load_word,
    input logic [15:0]       flag_word
);
    localparam int          BYTE_W  = DATA_W / 2;
    localparam logic [15:0] WR_MASK = 16'h0FD5;
    localparam logic [15:0] AR_MASK = 16'h08D5;

    // R2
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[1] && !flag_word[3] && !flag_word[5] && (flag_word[15:12] == 4'h0));

    // R12
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> flag_word == (($past(load_word) & WR_MASK) | 16'h0002));

    // R10
    hold_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !load_en) |=> (flag_word & AR_MASK) == ($past(flag_word) & AR_MASK));

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && clr_int) |=> !flag_word[9]);

    // R11
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(set_trap || clr_trap || set_int || clr_int || set_dir || clr_dir))
        |=> flag_word[10:8] == $past(flag_word[10:8]));

    // R5
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en && size_word && (alu_res == '0)) |=> flag_word[6]);

    // R6
    sign_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !load_en && !size_word) |=> flag_word[7] == $past(alu_res[BYTE_W-1]));
endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .size_word (size_word),
    .alu_res   (alu_res),
    .set_trap  (set_trap),
    .clr_trap  (clr_trap),
    .set_int   (set_int),
    .clr_int   (clr_int),
    .set_dir   (set_dir),
    .clr_dir   (clr_dir),
    .load_en   (load_en),
    .load_word (load_word),
    .flag_word (flag_word)
);

// File: tb/status_flag_unit_test.sv
`timescale 1ns/1ps
module status_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        upd_en, op_sub, size_word;
    logic [15:0] opnd_a, opnd_b, alu_res;
    logic        set_trap, clr_trap, set_int, clr_int, set_dir, clr_dir;
    logic        load_en;
    logic [15:0] load_word;
    logic [15:0] flag_word;

    int n_chk  = 0;
    int n_fail = 0;

    logic [2:0] exp_ctl;

    always #2 clk = ~clk;

    status_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sub(op_sub),
        .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_res(alu_res), .set_trap(set_trap), .clr_trap(clr_trap),
        .set_int(set_int), .clr_int(clr_int), .set_dir(set_dir),
        .clr_dir(clr_dir), .load_en(load_en), .load_word(load_word),
        .flag_word(flag_word)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle();
        upd_en = 0; op_sub = 0; size_word = 0;
        opnd_a = '0; opnd_b = '0; alu_res = '0;
        set_trap = 0; clr_trap = 0; set_int = 0; clr_int = 0;
        set_dir = 0; clr_dir = 0; load_en = 0; load_word = '0;
    endtask

    // Drive one operation at a falling edge; check after the next rising edge (R13).
    task automatic run_op(bit sub, bit word, logic [15:0] a, logic [15:0] b, logic [7:0] junk);
        longint w, mask, half, ua, ub, raw, r, sa, sb, sr;
        bit cf, af, of, zf, sf, pf;
        logic [7:0] lo;
        w    = word ? 16 : 8;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        ua   = longint'(a) & mask;
        ub   = longint'(b) & mask;
        raw  = sub ? ua - ub : ua + ub;
        r    = raw & mask;
        cf   = sub ? (ua < ub) : (raw > mask);
        af   = sub ? ((ua & 15) < (ub & 15)) : (((ua & 15) + (ub & 15)) > 15);
        sa   = (ua >= half) ? ua - 2 * half : ua;
        sb   = (ub >= half) ? ub - 2 * half : ub;
        sr   = sub ? sa - sb : sa + sb;
        of   = (sr > half - 1) || (sr < -half);
        zf   = (r == 0);
        sf   = (r >= half);
        lo   = r[7:0];
        pf   = ~^lo;
        upd_en = 1; op_sub = sub; size_word = word;
        opnd_a = a; opnd_b = b;
        alu_res = word ? r[15:0] : {junk, r[7:0]};
        @(negedge clk);
        chk("R3", "carry",    {15'b0, flag_word[0]},  {15'b0, cf});
        chk("R4", "aux",      {15'b0, flag_word[4]},  {15'b0, af});
        chk("R5", "zero",     {15'b0, flag_word[6]},  {15'b0, zf});
        chk("R6", "sign",     {15'b0, flag_word[7]},  {15'b0, sf});
        chk("R7", "overflow", {15'b0, flag_word[11]}, {15'b0, of});
        chk("R8", "parity",   {15'b0, flag_word[2]},  {15'b0, pf});
        chk("R11", "ctrl kept", {13'b0, flag_word[10:8]}, {13'b0, exp_ctl});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] saved;
        logic [15:0] lfsr;
        idle();
        rst_n = 0;
        exp_ctl = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1", "word in reset", flag_word, 16'h0002);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "word after reset", flag_word, 16'h0002);

        // R11 control flags: bits [10:8] = {dir, intr, trap}
        set_int = 1;
        @(negedge clk);
        chk("R11", "int set", {13'b0, flag_word[10:8]}, 16'h0002);
        set_int = 0; set_dir = 1; clr_dir = 1; set_trap = 1;
        @(negedge clk);
        chk("R11", "clear wins", {13'b0, flag_word[10:8]}, 16'h0003);
        clr_dir = 0; set_trap = 0;
        @(negedge clk);
        chk("R11", "dir set", {13'b0, flag_word[10:8]}, 16'h0007);
        set_dir = 0; clr_trap = 1;
        @(negedge clk);
        chk("R11", "trap clear", {13'b0, flag_word[10:8]}, 16'h0006);
        clr_trap = 0;
        exp_ctl = 3'b110;

        // R9 upper byte ignored: low bytes 80+80 give 00, upper bytes differ
        run_op(0, 0, 16'h1280, 16'h3480, 8'h46);
        chk("R9", "byte zero with upper junk", {15'b0, flag_word[6]}, 16'h0001);

        // exhaustive byte sweep, add and subtract (R3..R9)
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run_op(s[0], 0,
                           {8'(a ^ 8'hA5), 8'(a)},
                           {8'(b + 8'h3C), 8'(b)},
                           8'(a ^ b ^ 8'h5A));

        // word corner pairs
        run_op(0, 1, 16'h7FFF, 16'h0001, 8'h00);
        chk("R7", "word 7FFF+1 overflow", {15'b0, flag_word[11]}, 16'h0001);
        run_op(1, 1, 16'h8000, 16'h0001, 8'h00);
        chk("R7", "word 8000-1 overflow", {15'b0, flag_word[11]}, 16'h0001);
        run_op(0, 1, 16'hFFFF, 16'h0001, 8'h00);
        chk("R3", "word FFFF+1 carry", {15'b0, flag_word[0]}, 16'h0001);
        run_op(1, 1, 16'h0000, 16'h0001, 8'h00);
        chk("R3", "word 0-1 borrow", {15'b0, flag_word[0]}, 16'h0001);
        run_op(1, 1, 16'h1234, 16'h1234, 8'h00);

        // pseudo-random word pairs
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr ^ 16'(k);
            run_op(k[0], 1, a, b, 8'h00);
        end

        // R10 hold without enable
        saved = flag_word;
        upd_en = 0; opnd_a = 16'h00FF; opnd_b = 16'h0001; alu_res = 16'h0000;
        op_sub = 1; size_word = 1;
        @(negedge clk);
        chk("R10", "held without update", flag_word, saved);
        @(negedge clk);
        chk("R10", "still held", flag_word, saved);

        // R12 load with priority, R2 fixed bits forced
        load_en = 1; load_word = 16'hFFFF; upd_en = 1; clr_int = 1; clr_dir = 1;
        @(negedge clk);
        chk("R12", "load all ones", flag_word, 16'h0FD7);
        clr_int = 0; clr_dir = 0; upd_en = 0;
        load_word = 16'h0000;
        @(negedge clk);
        chk("R2", "load zero keeps bit 1", flag_word, 16'h0002);
        load_word = 16'h0A55; set_trap = 1;
        @(negedge clk);
        chk("R12", "load pattern", flag_word, 16'h0A57);
        load_en = 0; set_trap = 0;
        exp_ctl = 3'b010;
        run_op(0, 1, 16'h0001, 16'h0001, 8'h00);
        chk("R13", "word after update", flag_word, 16'h0202);

        summary();
        $finish;
    end
endmodule